// File: doc/BRIEF.md
# IQ Mismatch Coefficient Calculator

This block turns receive-path IQ imbalance measurements into correction coefficients for up to three receive chains. A measurement engine outside the block delivers, for every chain, three 32-bit words per sample: I-branch power, Q-branch power and the signed I/Q cross-correlation. Each collect strobe adds one sample into per-chain running sums. A start-calibration pulse clears those sums before a new measurement run.

When the run is complete, a process strobe carries the number of active chains. For each active chain in turn, the block derives two coarse power-based denominators. It then divides with one shared multi-cycle restoring divider and forms an I (phase) coefficient and a Q (gain) coefficient. Both are saturated and written as 7-bit two's-complement values. Once the last chain is handled, a sticky correction-enable output is raised so the datapath can apply the coefficients.

Top module: `iqc_coef_calc`

## Requirements
- R1: After reset, busy and corr_en are 0 and every coefficient output field is 0.
- R2: Each cycle with collect high and busy low adds the chain's I power, Q power and correlation inputs into three 32-bit wrap-around sums for that chain. A cycle with cal_start high clears all sums instead, and takes priority over collect.
- R3: When a chain's correlation sum, read as unsigned, is greater than 0x80000000, its two's-complement magnitude is used and the chain is marked negative. Otherwise the sum itself is used and the chain is marked non-negative.
- R4: The I denominator is ((Isum>>1)+(Qsum>>1))>>8 and the Q denominator is Qsum>>6. If either one is zero, that chain's coefficient fields keep their previous values.
- R5: The I coefficient is the correlation magnitude divided by the I denominator, saturated to the range -63..+63, and then negated when the chain is marked non-negative.
- R6: The Q coefficient is Isum divided by the Q denominator, minus 64, saturated to the range -63..+63. The value -64 therefore never appears on either output.
- R7: Coefficient outputs are 7-bit two's complement. Chain k occupies bits [7k+6:7k] of coef_i and of coef_q.
- R8: A process strobe seen while busy is low, carrying count n, updates chains 0..n-1 only. Chains n and above keep their previous coefficients. When n is 0, no chain is updated.
- R9: busy is high from the cycle after an accepted process strobe until all chains are finished. corr_en becomes 1 on the edge at which busy falls and then stays 1 until reset. collect and process are ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_start | input | 1 | Clears all measurement sums |
| collect | input | 1 | Adds one measurement sample per chain |
| meas_ipow | input | 96 | I power per chain, 32 bits each, chain k at [32k+31:32k] |
| meas_qpow | input | 96 | Q power per chain |
| meas_corr | input | 96 | Signed correlation per chain |
| process | input | 1 | Starts coefficient computation |
| chain_count | input | 2 | Number of active chains for the process strobe |
| busy | output | 1 | Computation in progress |
| coef_i | output | 21 | I coefficients, 7 bits per chain |
| coef_q | output | 21 | Q coefficients, 7 bits per chain |
| corr_en | output | 1 | Correction enable, sticky |

## Verification
The assertions assume that process and collect are single-cycle pulses issued from an idle state. They also assume chain_count never exceeds the number of chains. The stimulus keeps to these rules by waiting for busy to fall before it strobes again. Each collect lasts one cycle, and the random power values are bounded so that the denominators are nonzero, except in directed cases that force a zero denominator on purpose. The one exception is a deliberate collect pulse during busy, which exercises the ignore rule of R9.

// File: rtl/iqc_pkg.sv
// Shared types and arithmetic helpers for the IQ coefficient calculator.
package iqc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_DIV_I,
        ST_DIV_Q,
        ST_DONE
    } seq_state_t;

    // Saturate a 32-bit two's-complement value to -63..+63 (8-bit result).
    function automatic logic signed [7:0] sat63(input logic [31:0] v);
        logic signed [31:0] s;
        s = v;
        if (s >= 32'sd63)       return 8'sd63;
        else if (s <= -32'sd63) return -8'sd63;
        else                    return s[7:0];
    endfunction

endpackage

// File: rtl/iqc_accum.sv
// Per-chain measurement accumulator.
// Holds three wrap-around sums; clear has priority over add.
// Assumes the caller gates add while a computation is running.
module iqc_accum #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             add,
    input  logic [ACC_W-1:0] in_i,
    input  logic [ACC_W-1:0] in_q,
    input  logic [ACC_W-1:0] in_c,
    output logic [ACC_W-1:0] sum_i,
    output logic [ACC_W-1:0] sum_q,
    output logic [ACC_W-1:0] sum_c
);

    // Clear, or add one sample into the three sums.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sum_i <= '0;
            sum_q <= '0;
            sum_c <= '0;
        end else if (add) begin
            sum_i <= sum_i + in_i;
            sum_q <= sum_q + in_q;
            sum_c <= sum_c + in_c;
        end
    end

endmodule

// File: rtl/iqc_divider.sv
// Unsigned restoring divider, one quotient bit per cycle.
// Pulses done for one cycle W cycles after start; quotient is held after that.
// Assumes divisor is nonzero and start is only issued when idle.
module iqc_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quotient
);

    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     rem_r;
    logic [W-1:0]     dvs_r;
    logic [CNT_W-1:0] cnt_r;
    logic             run_r;
    logic [W:0]       shifted;
    logic [W+1:0]     diff;

    assign shifted = {rem_r, quotient[W-1]};
    assign diff    = {1'b0, shifted} - {2'b00, dvs_r};

    // Iterate one trial subtraction per cycle while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_r    <= '0;
            dvs_r    <= '0;
            cnt_r    <= '0;
            run_r    <= 1'b0;
            done     <= 1'b0;
            quotient <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem_r    <= '0;
                dvs_r    <= divisor;
                quotient <= dividend;
                cnt_r    <= CNT_W'(W);
                run_r    <= 1'b1;
            end else if (run_r) begin
                if (!diff[W+1]) begin
                    rem_r    <= diff[W-1:0];
                    quotient <= {quotient[W-2:0], 1'b1};
                end else begin
                    rem_r    <= shifted[W-1:0];
                    quotient <= {quotient[W-2:0], 1'b0};
                end
                cnt_r <= cnt_r - 1'b1;
                if (cnt_r == CNT_W'(1)) begin
                    run_r <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/iqc_coef_calc.sv
// IQ mismatch coefficient calculator (top).
// Accumulates per-chain measurements, then on a process strobe walks the
// active chains, dividing with one shared divider, and writes saturated
// 7-bit coefficients. Raises a sticky correction enable when finished.
// Assumes chain_count <= NUM_CHAINS and single-cycle strobes.
module iqc_coef_calc
    import iqc_pkg::*;
#(
    parameter int NUM_CHAINS = 3,
    parameter int ACC_W      = 32,
    parameter int COEF_W     = 7,
    parameter int CNT_W      = $clog2(NUM_CHAINS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cal_start,
    input  logic                       collect,
    input  logic [NUM_CHAINS*ACC_W-1:0] meas_ipow,
    input  logic [NUM_CHAINS*ACC_W-1:0] meas_qpow,
    input  logic [NUM_CHAINS*ACC_W-1:0] meas_corr,
    input  logic                       process,
    input  logic [CNT_W-1:0]           chain_count,
    output logic                       busy,
    output logic [NUM_CHAINS*COEF_W-1:0] coef_i,
    output logic [NUM_CHAINS*COEF_W-1:0] coef_q,
    output logic                       corr_en
);

    localparam int IDX_W = (NUM_CHAINS > 1) ? $clog2(NUM_CHAINS) : 1;
    localparam logic [ACC_W-1:0] NEG_LIMIT = {1'b1, {(ACC_W-1){1'b0}}};

    seq_state_t       state_r;
    logic [IDX_W-1:0] idx_r;
    logic [IDX_W-1:0] last_r;
    logic             neg_r;
    logic [ACC_W-1:0] qden_r;
    logic [ACC_W-1:0] iquot_r;

    logic [ACC_W-1:0] sum_i [NUM_CHAINS];
    logic [ACC_W-1:0] sum_q [NUM_CHAINS];
    logic [ACC_W-1:0] sum_c [NUM_CHAINS];
    logic [COEF_W-1:0] ci_r [NUM_CHAINS];
    logic [COEF_W-1:0] cq_r [NUM_CHAINS];

    logic             add_en;
    logic [ACC_W-1:0] sel_i, sel_q, sel_c;
    logic [ACC_W-1:0] corr_mag, iden, qden;
    logic             corr_neg;
    logic             div_start, div_done;
    logic [ACC_W-1:0] div_a, div_b, div_q;
    logic signed [7:0] isat, qsat;

    assign busy   = (state_r != ST_IDLE);
    assign add_en = collect & ~busy;

    // One accumulator per chain, with flattened inputs sliced out.
    for (genvar k = 0; k < NUM_CHAINS; k++) begin : g_chain
        iqc_accum #(.ACC_W(ACC_W)) i_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (cal_start),
            .add   (add_en),
            .in_i  (meas_ipow[k*ACC_W +: ACC_W]),
            .in_q  (meas_qpow[k*ACC_W +: ACC_W]),
            .in_c  (meas_corr[k*ACC_W +: ACC_W]),
            .sum_i (sum_i[k]),
            .sum_q (sum_q[k]),
            .sum_c (sum_c[k])
        );
        assign coef_i[k*COEF_W +: COEF_W] = ci_r[k];
        assign coef_q[k*COEF_W +: COEF_W] = cq_r[k];
    end

    // Select the chain under computation and derive magnitude and denominators.
    always_comb begin
        sel_i    = sum_i[idx_r];
        sel_q    = sum_q[idx_r];
        sel_c    = sum_c[idx_r];
        corr_neg = (sel_c > NEG_LIMIT);
        corr_mag = corr_neg ? (~sel_c + 1'b1) : sel_c;
        iden     = ((sel_i >> 1) + (sel_q >> 1)) >> 8;
        qden     = sel_q >> 6;
    end

    // Drive the shared divider's operands from the sequencer state.
    always_comb begin
        div_start = 1'b0;
        div_a     = corr_mag;
        div_b     = iden;
        if (state_r == ST_SETUP && iden != '0 && qden != '0) begin
            div_start = 1'b1;
        end else if (state_r == ST_DIV_I && div_done) begin
            div_start = 1'b1;
            div_a     = sel_i;
            div_b     = qden_r;
        end
    end

    // Saturate the two coefficients, with the polarity-dependent sign flip.
    always_comb begin
        isat = sat63(iquot_r);
        if (!neg_r) isat = -isat;
        qsat = sat63(div_q - ACC_W'(64));
    end

    iqc_divider #(.W(ACC_W)) i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (div_a),
        .divisor  (div_b),
        .done     (div_done),
        .quotient (div_q)
    );

    // Sequencer: walk the active chains and write their coefficients.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_r <= ST_IDLE;
            idx_r   <= '0;
            last_r  <= '0;
            neg_r   <= 1'b0;
            qden_r  <= '0;
            iquot_r <= '0;
            corr_en <= 1'b0;
            for (int k = 0; k < NUM_CHAINS; k++) begin
                ci_r[k] <= '0;
                cq_r[k] <= '0;
            end
        end else begin
            case (state_r)
                ST_IDLE: if (process) begin
                    idx_r   <= '0;
                    last_r  <= IDX_W'(chain_count - 1'b1);
                    state_r <= (chain_count == '0) ? ST_DONE : ST_SETUP;
                end
                ST_SETUP: begin
                    neg_r  <= corr_neg;
                    qden_r <= qden;
                    if (iden != '0 && qden != '0) begin
                        state_r <= ST_DIV_I;
                    end else if (idx_r == last_r) begin
                        state_r <= ST_DONE;
                    end else begin
                        idx_r <= idx_r + 1'b1;
                    end
                end
                ST_DIV_I: if (div_done) begin
                    iquot_r <= div_q;
                    state_r <= ST_DIV_Q;
                end
                ST_DIV_Q: if (div_done) begin
                    ci_r[idx_r] <= isat[COEF_W-1:0];
                    cq_r[idx_r] <= qsat[COEF_W-1:0];
                    if (idx_r == last_r) begin
                        state_r <= ST_DONE;
                    end else begin
                        idx_r   <= idx_r + 1'b1;
                        state_r <= ST_SETUP;
                    end
                end
                ST_DONE: begin
                    corr_en <= 1'b1;
                    state_r <= ST_IDLE;
                end
                default: state_r <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/iqc_coef_calc_chk.sv
// Property checker for iqc_coef_calc, attached with bind.
// Assumes strobes are only issued while the block is idle.
module iqc_coef_calc_chk #(
    parameter int NUM_CHAINS = 3,
    parameter int COEF_W     = 7
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         process,
    input logic                         busy,
    input logic                         corr_en,
    input logic [NUM_CHAINS*COEF_W-1:0] coef_i,
    input logic [NUM_CHAINS*COEF_W-1:0] coef_q
);

    AST_BUSY_AFTER_PROCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (process && !busy) |=> busy); // R9

    AST_ENABLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        corr_en |=> corr_en); // R9

    AST_ENABLE_AT_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> corr_en); // R9

    AST_COEF_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(coef_i) && $stable(coef_q))); // R8

    for (genvar k = 0; k < NUM_CHAINS; k++) begin : g_rng
        AST_NO_MINUS_64: assert property (@(posedge clk) disable iff (!rst_n)
            (coef_i[k*COEF_W +: COEF_W] != {1'b1, {(COEF_W-1){1'b0}}}) &&
            (coef_q[k*COEF_W +: COEF_W] != {1'b1, {(COEF_W-1){1'b0}}})); // R6
    end

endmodule

bind iqc_coef_calc iqc_coef_calc_chk #(
    .NUM_CHAINS (NUM_CHAINS),
    .COEF_W     (COEF_W)
) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .process (process),
    .busy    (busy),
    .corr_en (corr_en),
    .coef_i  (coef_i),
    .coef_q  (coef_q)
);

// File: tb/test_iqc_coef_calc.sv
module test_iqc_coef_calc;

    localparam int N = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cal_start = 1'b0;
    logic          collect = 1'b0;
    logic [N*32-1:0] meas_ipow = '0;
    logic [N*32-1:0] meas_qpow = '0;
    logic [N*32-1:0] meas_corr = '0;
    logic          process = 1'b0;
    logic [1:0]    chain_count = '0;
    logic          busy;
    logic [N*7-1:0] coef_i;
    logic [N*7-1:0] coef_q;
    logic          corr_en;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    bit [31:0] m_i [N];
    bit [31:0] m_q [N];
    bit [31:0] m_c [N];
    bit [6:0]  e_i [N];
    bit [6:0]  e_q [N];

    always #5 clk = ~clk;

    iqc_coef_calc i_iqc_coef_calc (
        .clk         (clk),
        .rst_n       (rst_n),
        .cal_start   (cal_start),
        .collect     (collect),
        .meas_ipow   (meas_ipow),
        .meas_qpow   (meas_qpow),
        .meas_corr   (meas_corr),
        .process     (process),
        .chain_count (chain_count),
        .busy        (busy),
        .coef_i      (coef_i),
        .coef_q      (coef_q),
        .corr_en     (corr_en)
    );

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit [6:0] sat(input bit [31:0] v);
        int s;
        s = int'(v);
        if (s >= 63) return 7'd63;
        if (s <= -63) return 7'(-63);
        return v[6:0];
    endfunction

    // Reference per-chain coefficient computation (R3..R7).
    function automatic bit calc(input bit [31:0] pi, input bit [31:0] pq, input bit [31:0] pc,
                                output bit [6:0] ci, output bit [6:0] cq);
        bit [31:0] mag, iden, qden, iq, qq;
        bit neg;
        neg  = pc > 32'h8000_0000;
        mag  = neg ? (32'h0 - pc) : pc;
        iden = ((pi >> 1) + (pq >> 1)) >> 8;
        qden = pq >> 6;
        ci = '0; cq = '0;
        if (iden == 0 || qden == 0) return 1'b0;
        iq = mag / iden;
        ci = sat(iq);
        if (!neg) ci = 7'(-ci);
        qq = pi / qden - 32'd64;
        cq = sat(qq);
        return 1'b1;
    endfunction

    task automatic do_clear();
        @(negedge clk) cal_start = 1'b1;
        @(negedge clk) cal_start = 1'b0;
        for (int k = 0; k < N; k++) begin m_i[k] = 0; m_q[k] = 0; m_c[k] = 0; end
    endtask

    task automatic do_collect(input bit [31:0] vi [N], input bit [31:0] vq [N], input bit [31:0] vc [N]);
        @(negedge clk);
        for (int k = 0; k < N; k++) begin
            meas_ipow[k*32 +: 32] = vi[k];
            meas_qpow[k*32 +: 32] = vq[k];
            meas_corr[k*32 +: 32] = vc[k];
            m_i[k] += vi[k]; m_q[k] += vq[k]; m_c[k] += vc[k];
        end
        collect = 1'b1;
        @(negedge clk) collect = 1'b0;
    endtask

    // Process n chains; optionally pulse collect while busy (must be ignored).
    task automatic do_process(input int n, input bit poke);
        int w;
        bit [6:0] ci, cq;
        @(negedge clk);
        process = 1'b1;
        chain_count = 2'(n);
        @(negedge clk) process = 1'b0;
        chk(busy == 1'b1, "R9 busy after process", busy, 1);
        if (poke) begin
            meas_ipow = {N{32'd9999}};
            meas_qpow = {N{32'd5555}};
            meas_corr = {N{32'd123456}};
            collect = 1'b1;
            @(negedge clk) collect = 1'b0;
        end
        w = 0;
        while (busy && w < 500) begin @(negedge clk); w++; end
        chk(w < 500, "R9 busy falls", w, 0);
        for (int k = 0; k < n; k++)
            if (calc(m_i[k], m_q[k], m_c[k], ci, cq)) begin e_i[k] = ci; e_q[k] = cq; end
        for (int k = 0; k < N; k++) begin
            chk(coef_i[k*7 +: 7] == e_i[k], $sformatf("R5 R7 R8 coef_i chain %0d", k),
                coef_i[k*7 +: 7], e_i[k]);
            chk(coef_q[k*7 +: 7] == e_q[k], $sformatf("R6 R7 R8 coef_q chain %0d", k),
                coef_q[k*7 +: 7], e_q[k]);
        end
        chk(corr_en == 1'b1, "R9 corr_en", corr_en, 1);
    endtask

    task automatic one_sample(input bit [31:0] pi, input bit [31:0] pq, input bit [31:0] pc, input int n);
        bit [31:0] vi [N], vq [N], vc [N];
        for (int k = 0; k < N; k++) begin vi[k] = pi; vq[k] = pq; vc[k] = pc; end
        do_clear();
        do_collect(vi, vq, vc);
        do_process(n, 1'b0);
    endtask

    initial begin
        bit [31:0] vi [N], vq [N], vc [N];
        int ns;
        void'($urandom(32'd20240611));
        for (int k = 0; k < N; k++) begin e_i[k] = 0; e_q[k] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0, "R1 busy", busy, 0);
        chk(corr_en == 0, "R1 corr_en", corr_en, 0);
        chk(coef_i == '0, "R1 coef_i", coef_i, 0);
        chk(coef_q == '0, "R1 coef_q", coef_q, 0);

        // R8: count 0 updates nothing but still raises enable
        one_sample(32'd40000, 32'd40000, 32'd300, 0);

        // Directed corners
        one_sample(32'd40000, 32'd40000, 32'd300, 3);           // R5 positive corr, flag clear -> negated
        one_sample(32'd40000, 32'd40000, 32'hFFFF_FF00, 3);     // R3 negative corr magnitude
        one_sample(32'd40000, 32'd40000, 32'd100000, 3);        // R5 clamp +/-63
        one_sample(32'd40000, 32'd40000, 32'h8000_0001, 3);     // R3 just above limit
        one_sample(32'd400000, 32'd40000, 32'd0, 3);            // R6 clamp +63
        one_sample(32'd100, 32'd40000, 32'd0, 3);               // R6 clamp -63, never -64
        one_sample(32'd40000, 32'd63, 32'd5000, 3);             // R4 qden zero -> unchanged
        one_sample(32'd200, 32'd200, 32'd5000, 3);              // R4 iden zero -> unchanged
        one_sample(32'd30000, 32'd50000, 32'd2000, 1);          // R8 only chain 0

        // R2 accumulation with random multi-sample runs; R9 collect ignored while busy
        for (int r = 0; r < 25; r++) begin
            do_clear();
            ns = $urandom_range(1, 6);
            for (int s = 0; s < ns; s++) begin
                for (int k = 0; k < N; k++) begin
                    vi[k] = $urandom_range(2000, 90000);
                    vq[k] = $urandom_range(2000, 90000);
                    vc[k] = 32'($urandom_range(0, 16000)) - 32'd8000;
                end
                do_collect(vi, vq, vc);
            end
            do_process($urandom_range(0, 3), r[0]);
            if (r[0]) do_process(3, 1'b0); // R2 R9 sums untouched by collect during busy
        end

        // R2 cal_start priority over collect
        @(negedge clk);
        cal_start = 1'b1; collect = 1'b1;
        meas_ipow = {N{32'd77777}};
        @(negedge clk);
        cal_start = 1'b0; collect = 1'b0;
        for (int k = 0; k < N; k++) begin m_i[k] = 0; m_q[k] = 0; m_c[k] = 0; end
        for (int k = 0; k < N; k++) begin vi[k] = 32'd50000; vq[k] = 32'd20000; vc[k] = 32'd700; end
        do_collect(vi, vq, vc);
        do_process(3, 1'b0);

        finish_run();
    end

endmodule